// File: doc/BRIEF.md
# SPI Byte Shift Engine

This block moves one byte in each direction over a four-wire serial bus in a single full-duplex exchange. A front end that owns chip selects, register decoding and bus arbitration pulses `start` together with the byte to send, a 4-bit rate exponent and the two clock-shape bits. The engine then drives the serial clock and the outgoing data line and samples the incoming line. It holds `busy` high until the received byte is valid on `rxByte`.

The serial clock comes from a power-of-two prescaler. Rate code `n` makes each half period of `sclk` last 2^n system cycles, so the full clock period is 2^(n+1) system cycles. Rate, polarity and phase are captured when a transfer is accepted. This lets the front end reprogram them for the next device while the current byte is still shifting.

Top module: `spi_byte_engine`

## Requirements
- R1: With captured rate code n (0..15), every half period of `sclk` during a transfer lasts exactly 2^n system cycles. The first `sclk` edge comes 2^n cycles after the clock edge that accepted `start`.
- R2: Code 15 is the slowest setting: the first `sclk` edge of a transfer comes 32768 system cycles after acceptance. After reset the captured code is 15.
- R3: Each transfer makes exactly 16 `sclk` edges. It sends the 8 bits of `txByte` and receives 8 bits from `miso`, both most significant bit first. `rxByte` holds the received bits with the first one received in bit 7.
- R4: With `cpha`=0, `mosi` shows bit 7 from the acceptance edge onward. `miso` is sampled on `sclk` edges 1,3,...,15. `mosi` moves to the next bit on edges 2,4,...,14.
- R5: With `cpha`=1, `mosi` presents bits 7 down to 0 on `sclk` edges 1,3,...,15, and `miso` is sampled on edges 2,4,...,16.
- R6: While idle, `sclk` copies `cpol` with one register stage of delay. A transfer starts and ends with `sclk` at the captured polarity.
- R7: `busy` rises on the edge that accepts `start` and stays high for exactly 16·2^n cycles. It falls on the same edge as the 16th `sclk` edge, and `rxByte` is updated on that edge.
- R8: A `start` pulse while `busy` is high is ignored: the running transfer keeps its length, its byte and its result.
- R9: Changes to `divCode`, `cpol` or `cpha` while `busy` is high do not affect the running transfer.
- R10: Reset drives `sclk`, `mosi`, `busy` and `rxByte` to zero.
- R11: `rxByte` holds its value from the end of one transfer to the end of the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| txByte | input | 8 | Byte to send (zero for receive-only) |
| divCode | input | 4 | Rate exponent n, half period 2^n cycles |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase select |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| busy | output | 1 | Transfer in progress |
| rxByte | output | 8 | Last received byte |

## Verification
The hardest cases to reach from the ports are those where the inputs move while a byte is in flight. These are a second `start` pulse, or a new rate and clock shape arriving halfway through a transfer. The stimulus drives both cases at a fixed cycle inside a running transfer. A behavioural reference model, which captured its settings at acceptance, then shows any leak into the transfer as a wrong edge time or a wrong bit. A loopback path from `mosi` to `miso` checks bit order in all four clock shapes. A pseudo-random `miso` stream shows the exact sampling edge. For the slowest rate, the test times only the first edge and then resets.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

  // Strobes from the sequencer to the shift datapath, all single-cycle.
  typedef struct packed {
    logic load;    // capture the outgoing byte and present its top bit
    logic shift;   // advance the outgoing bit
    logic sample;  // capture one incoming bit
    logic finish;  // publish the received byte
  } stb_t;

endpackage

// File: rtl/spi_byte_ctrl.sv
module spi_byte_ctrl
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIV_W-1:0] divCode,
  input  logic             cpol,
  input  logic             cpha,
  output logic             busy,
  output logic             sclk,
  output stb_t             stb,
  output logic [DIV_W-1:0] divQ,
  output logic             cpolQ,
  output logic             cphaQ
);

  localparam int HALF_W = (1 << DIV_W) - 1;   // widest half-period count
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);

  logic [HALF_W-1:0] halfCnt;
  logic [HALF_W-1:0] halfLim;
  logic [EDGE_W-1:0] edgeCnt;
  logic              tick;
  logic              leading;
  logic              lastEdge;

  // 2^n - 1 without a wider intermediate: clear n low bits of all-ones, invert.
  assign halfLim  = ~({HALF_W{1'b1}} << divQ);
  assign tick     = busy && (halfCnt == halfLim);
  assign leading  = ~edgeCnt[0];                      // next edge is odd-numbered
  assign lastEdge = (edgeCnt == EDGE_W'(EDGES - 1));

  always_comb begin
    stb        = '0;
    stb.load   = !busy && start;
    stb.sample = tick && (leading != cphaQ);
    stb.shift  = tick && (leading == cphaQ) && !lastEdge;
    stb.finish = tick && lastEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      halfCnt <= '0;
      edgeCnt <= '0;
      divQ    <= '1;
      cpolQ   <= 1'b0;
      cphaQ   <= 1'b0;
    end else if (!busy) begin
      sclk <= cpol;
      if (start) begin
        busy    <= 1'b1;
        halfCnt <= '0;
        edgeCnt <= '0;
        divQ    <= divCode;
        cpolQ   <= cpol;
        cphaQ   <= cpha;
      end
    end else if (tick) begin
      halfCnt <= '0;
      sclk    <= ~sclk;
      edgeCnt <= edgeCnt + 1'b1;
      if (lastEdge) begin
        busy <= 1'b0;
      end
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_byte_dp.sv
module spi_byte_dp
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  stb_t              stb,
  input  logic [DATA_W-1:0] txByte,
  input  logic              cphaIn,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxByte
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rxNext;

  assign rxNext = stb.sample ? {rxShift[MSB-1:0], miso} : rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      mosi    <= 1'b0;
      rxByte  <= '0;
    end else begin
      if (stb.load) begin
        mosi    <= txByte[MSB];
        // trailing-phase mode re-presents the top bit on the first edge
        txShift <= cphaIn ? txByte : {txByte[MSB-1:0], 1'b0};
        rxShift <= '0;
      end else begin
        if (stb.shift) begin
          mosi    <= txShift[MSB];
          txShift <= {txShift[MSB-1:0], 1'b0};
        end
        rxShift <= rxNext;
      end
      if (stb.finish) begin
        rxByte <= rxNext;
      end
    end
  end

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] txByte,
  input  logic [DIV_W-1:0]  divCode,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic [DATA_W-1:0] rxByte
);

  stb_t             stb;
  logic [DIV_W-1:0] divQ;
  logic             cpolQ;
  logic             cphaQ;

  spi_byte_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .divCode (divCode),
    .cpol    (cpol),
    .cpha    (cpha),
    .busy    (busy),
    .sclk    (sclk),
    .stb     (stb),
    .divQ    (divQ),
    .cpolQ   (cpolQ),
    .cphaQ   (cphaQ)
  );

  spi_byte_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .txByte (txByte),
    .cphaIn (cpha),
    .miso   (miso),
    .mosi   (mosi),
    .rxByte (rxByte)
  );

endmodule

// File: rtl/spi_byte_engine_chk.sv
module spi_byte_engine_chk #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              cpol,
  input logic              sclk,
  input logic              busy,
  input logic [DATA_W-1:0] rxByte,
  input logic [DIV_W-1:0]  divQ,
  input logic              cpolQ,
  input logic              cphaQ
);

  localparam int GAP_W = (1 << DIV_W) + 1;
  localparam int CNT_W = $clog2(2 * DATA_W) + 1;

  logic             sclkQ;
  logic             busyQ;
  logic [GAP_W-1:0] gap;
  logic [CNT_W-1:0] togCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ  <= 1'b0;
      busyQ  <= 1'b0;
      gap    <= '0;
      togCnt <= '0;
    end else begin
      sclkQ <= sclk;
      busyQ <= busy;
      if (!busy) togCnt <= '0;
      else if (busyQ && (sclk != sclkQ)) togCnt <= togCnt + 1'b1;
      if ((busy && !busyQ) || (sclk != sclkQ)) gap <= GAP_W'(1);
      else gap <= gap + 1'b1;
    end
  end

  // R1: spacing of serial clock edges inside a transfer
  assert_half_period_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busyQ && (sclk != sclkQ)) |-> (gap == (GAP_W'(1) << divQ)));

  // R3: the transfer ends on the 16th edge
  assert_edge_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ((togCnt == CNT_W'(2 * DATA_W - 1)) && (sclk != sclkQ)));

  // R7: busy rises only in answer to start
  assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R6: idle clock level follows polarity input
  assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy) && $past(rstN)) |-> (sclk == $past(cpol)));

  // R9: captured settings hold through the transfer
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(divQ) && $stable(cpolQ) && $stable(cphaQ)));

  // R11: result stays put while a byte is in flight
  assert_rx_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(rstN)) |-> $stable(rxByte));

endmodule

bind spi_byte_engine spi_byte_engine_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .cpol   (cpol),
  .sclk   (sclk),
  .busy   (busy),
  .rxByte (rxByte),
  .divQ   (divQ),
  .cpolQ  (cpolQ),
  .cphaQ  (cphaQ)
);

// File: tb/test_spi_byte_engine.sv
module test_spi_byte_engine;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic [3:0] divCode = 4'd0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       miso;
  logic       sclk, mosi, busy;
  logic [7:0] rxByte;

  logic       loopBack = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int nChk = 0;
  int nErr = 0;
  int cyc = 0;
  bit modelOn = 1'b0;

  // reference model state
  int mBusy = 0, mSclk = 0, mMosi = 0, mRx = 0;
  int mCnt = 0, mT = 0, mH = 1, mCph = 0, mTx = 0, mAcc = 0;

  always #5 clk = ~clk;

  assign miso = loopBack ? mosi : lfsr[0];

  spi_byte_engine i_spi_byte_engine (
    .clk(clk), .rstN(rstN), .start(start), .txByte(txByte),
    .divCode(divCode), .cpol(cpol), .cpha(cpha), .miso(miso),
    .sclk(sclk), .mosi(mosi), .busy(busy), .rxByte(rxByte)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural model, evaluated on the same edge as the design
  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mSclk = 0; mMosi = 0; mRx = 0; mAcc = 0;
    end else if (mBusy == 0) begin
      mSclk = int'(cpol);
      if (start) begin
        mBusy = 1; mH = 1 << divCode; mCph = int'(cpha); mTx = int'(txByte);
        mCnt = 0; mT = 0; mAcc = 0; mMosi = (mTx >> 7) & 1;
      end
    end else begin
      mCnt++;
      if (mCnt == mH) begin
        mCnt = 0; mT++; mSclk ^= 1;
        if ((mT % 2) != mCph) mAcc = ((mAcc << 1) | int'(miso)) & 255;
        if (mCph == 1 && (mT % 2) == 1) mMosi = (mTx >> (7 - (mT - 1) / 2)) & 1;
        if (mCph == 0 && (mT % 2) == 0 && mT < 16) mMosi = (mTx >> (7 - mT / 2)) & 1;
        if (mT == 16) begin mBusy = 0; mRx = mAcc; end
      end
    end
  end

  // compare every cycle away from the active edge, then advance noise
  always @(negedge clk) begin
    if (modelOn && rstN) begin
      check("R7", "busy", int'(busy), mBusy);
      check("R1", "sclk", int'(sclk), mSclk);
      check("R4", "mosi", int'(mosi), mMosi);
      check("R3", "rxByte", int'(rxByte), mRx);
    end
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nChk++; nErr++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
      $finish;
    end
  end

  task automatic kick(input logic [7:0] b, input logic [3:0] d, input logic p, input logic h);
    @(negedge clk); #1;
    txByte = b; divCode = d; cpol = p; cpha = h; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  // count cycles until busy falls; meddle 1 = second start, 2 = config change
  task automatic runLen(input int meddle, output int len);
    len = 0;
    while (busy) begin
      @(negedge clk);
      len++;
      if (len == 5 && meddle == 1) begin #1; start = 1'b1; txByte = 8'hFF; end
      if (len == 6 && meddle == 1) begin #1; start = 1'b0; end
      if (len == 5 && meddle == 2) begin #1; divCode = 4'd0; cpol = ~cpol; cpha = ~cpha; end
    end
  endtask

  task automatic resetCheck(input string tag);
    check(tag, "reset sclk", int'(sclk), 0);
    check(tag, "reset mosi", int'(mosi), 0);
    check(tag, "reset busy", int'(busy), 0);
    check(tag, "reset rxByte", int'(rxByte), 0);
  endtask

  initial begin
    int len;
    logic [7:0] pats [4] = '{8'hA5, 8'h3C, 8'h81, 8'h00};
    repeat (3) @(negedge clk);
    resetCheck("R10");
    #1 rstN = 1'b1;
    modelOn = 1'b1;
    repeat (2) @(negedge clk);

    // loopback in all four clock shapes: bit order and length
    loopBack = 1'b1;
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 4; k++) begin
        kick(pats[k], 4'(k % 2), m[1], m[0]);
        runLen(0, len);
        check("R7", "busy length", len, 16 << (k % 2));
        check(m[0] ? "R5" : "R4", "loopback byte", int'(rxByte), int'(pats[k]));
        repeat (2) @(negedge clk);
        check("R6", "idle level", int'(sclk), int'(m[1]));
      end
    end
    loopBack = 1'b0;

    // random incoming data, first edge timing at code 2
    for (int m = 0; m < 4; m++) begin
      kick(8'h5A ^ 8'(m), 4'd2, m[1], m[0]);
      len = 0;
      while (sclk == m[1]) begin @(negedge clk); len++; end
      check("R1", "first edge delay", len, 4);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
    end

    // R11: result holds while idle despite changing miso
    len = int'(rxByte);
    repeat (20) @(negedge clk);
    check("R11", "rxByte held", int'(rxByte), len);

    // R8: start pulse during transfer ignored
    kick(8'hC3, 4'd1, 1'b0, 1'b0);
    runLen(1, len);
    check("R8", "busy length with extra start", len, 32);
    repeat (3) @(negedge clk);

    // R9: settings change mid-transfer ignored
    kick(8'h96, 4'd1, 1'b0, 1'b0);
    runLen(2, len);
    check("R9", "busy length with new settings", len, 32);
    repeat (3) @(negedge clk);

    // R2: slowest code, first edge only, then reset
    kick(8'h00, 4'd15, 1'b0, 1'b1);
    len = 0;
    while (sclk == 1'b0 && len < 40000) begin @(negedge clk); len++; end
    check("R2", "first edge delay at code 15", len, 32768);
    #1 rstN = 1'b0;
    repeat (2) @(negedge clk);
    resetCheck("R10");

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end

endmodule